// File: doc/BRIEF.md
# Punctured Turbo Encoder

This block turns a stream of information bits into a turbo-coded serial stream. It collects one block of `BLK_LEN` bits (512 by default) through a valid/ready handshake into an internal buffer. It then runs two identical recursive systematic convolutional encoders side by side. The first sees the bits in arrival order. The second sees them through a quadratic permutation interleaver whose addresses are generated on the fly. The mother code has rate 1/3.

A puncturing stage drops parity bits under a repeating mask chosen by a 2-bit rate code. This gives rates 1/2, 2/3 or 7/8; code 1/3 punctures nothing. Each encoder is driven back to the all-zero state by three tail steps, and the tail bits are always sent. Coded bits leave one per clock cycle with no gaps, and a marker flags the final tail bit.

The buffer holds only one block. Input is therefore refused from the moment the last information bit is taken until the last coded bit has left.

Top module: `tc_turbo_enc`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: While `in_ready` is 1, each cycle with `in_valid` high takes `in_bit` as the next information bit, numbered u[0] upward. `in_ready` falls after u[BLK_LEN-1] is taken, and no coded bit appears before that.
- R3: The rate code on `in_rate` is sampled together with u[0] and holds for the whole block; later changes during the block are ignored. The codes are 00 = 1/3, 01 = 1/2, 10 = 2/3 and 11 = 7/8.
- R4: Each constituent encoder has feedback polynomial 1+D^2+D^3 and forward polynomial 1+D+D^3, and starts every block in the all-zero state.
- R5: At step i, encoder 1 is fed u[i] and encoder 2 is fed u[(31*i + 64*i*i) mod BLK_LEN].
- R6: For each information index i the output order is systematic u[i], then parity 1, then parity 2, with punctured bits skipped. The systematic bit is never removed.
- R7: The puncture phase restarts at 0 for i = 0. At rate 1/3 both parities are kept. At 1/2 the period is 2: parity 1 is kept at phase 0 and parity 2 at phase 1. At 2/3 the period is 4, keeping parity 1 at phase 0 and parity 2 at phase 2. At 7/8 the period is 14, keeping parity 1 at phase 0 and parity 2 at phase 7.
- R8: After the information bits come 3 tail steps, each emitting tail-systematic 1, tail-parity 1, tail-systematic 2, tail-parity 2 (12 bits, never punctured). The tail input cancels the feedback, so both encoders end in the all-zero state.
- R9: Coded bits leave one per cycle without gaps. `out_last` is high exactly on the final tail bit, and `in_ready` is high again the next cycle.
- R10: Idle cycles (`in_valid` low) between information bits do not change the coded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block buffer is accepting bits |
| in_bit | input | 1 | Information bit |
| in_rate | input | 2 | Code rate select, sampled with the first bit |
| out_valid | output | 1 | Coded bit present |
| out_bit | output | 1 | Coded bit |
| out_last | output | 1 | Final tail bit of the block |

## Verification
The hardest situation to reach is a block in which every puncture mask and the tail interact at the block edge. With 512 bits, the 7/8 mask ends partway through its 14-phase period, so the last kept parity-2 bit sits just before the tail. The stimulus runs full blocks at every rate back to back, which shows whether the phase and both encoder states carry over wrongly between blocks. It also flips `in_rate` after the first bit and inserts idle gaps in the input, and compares every output cycle against a behavioural model of the whole code.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        RATE_1_3 = 2'b00,
        RATE_1_2 = 2'b01,
        RATE_2_3 = 2'b10,
        RATE_7_8 = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        S_FILL = 2'd0,
        S_CODE = 2'd1,
        S_TAIL = 2'd2
    } phase_e;
endpackage

// File: rtl/tc_rsc_core.sv
// One trellis step of the 13/15 recursive systematic encoder.
// state_i[0] is the most recent register value.
module tc_rsc_core (
    input  logic [2:0] state_i,
    input  logic       u_i,
    input  logic       term_i,
    output logic       par_o,
    output logic       tail_o,
    output logic [2:0] next_o
);
    logic fb;
    logic a;

    always_comb begin
        fb     = state_i[1] ^ state_i[2];          // taps D^2, D^3
        a      = term_i ? 1'b0 : (u_i ^ fb);       // tail input cancels feedback
        par_o  = a ^ state_i[0] ^ state_i[2];      // taps 1, D, D^3
        tail_o = fb;
        next_o = {state_i[1], state_i[0], a};
    end
endmodule

// File: rtl/tc_punct.sv
// Puncture mask: which parities survive at a given phase, and period end.
module tc_punct
    import tc_pkg::*;
(
    input  rate_e      rate_i,
    input  logic [3:0] phase_i,
    output logic       keep1_o,
    output logic       keep2_o,
    output logic       wrap_o
);
    always_comb begin
        keep1_o = 1'b1;
        keep2_o = 1'b1;
        wrap_o  = 1'b1;
        case (rate_i)
            RATE_1_3: begin
                keep1_o = 1'b1;
                keep2_o = 1'b1;
                wrap_o  = 1'b1;
            end
            RATE_1_2: begin
                keep1_o = (phase_i == 4'd0);
                keep2_o = (phase_i == 4'd1);
                wrap_o  = (phase_i == 4'd1);
            end
            RATE_2_3: begin
                keep1_o = (phase_i == 4'd0);
                keep2_o = (phase_i == 4'd2);
                wrap_o  = (phase_i == 4'd3);
            end
            RATE_7_8: begin
                keep1_o = (phase_i == 4'd0);
                keep2_o = (phase_i == 4'd7);
                wrap_o  = (phase_i == 4'd13);
            end
            default: begin
                keep1_o = 1'b1;
                keep2_o = 1'b1;
                wrap_o  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tc_turbo_enc.sv
// Block turbo encoder: buffer, two constituent encoders, puncturing.
// BLK_LEN must be a power of two (interleaver arithmetic wraps modulo 2^IW).
module tc_turbo_enc
    import tc_pkg::*;
#(
    parameter int BLK_LEN  = 512,
    parameter int INTLV_F1 = 31,
    parameter int INTLV_F2 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic [1:0] in_rate,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);
    localparam int          IW       = $clog2(BLK_LEN);
    localparam int          N_ENC    = 2;
    localparam int          TAIL_LEN = 12;
    localparam logic [IW-1:0] LAST_IDX = IW'(BLK_LEN - 1);
    localparam logic [IW-1:0] DLT0     = IW'(INTLV_F1 + INTLV_F2);
    localparam logic [IW-1:0] DLT_INC  = IW'(2 * INTLV_F2);
    localparam logic [3:0]  TAIL_END = 4'(TAIL_LEN - 1);

    typedef struct packed {
        phase_e                       st;
        rate_e                        rate;
        logic [IW-1:0]                idx;
        logic [1:0]                   sub;
        logic [3:0]                   ph;
        logic [3:0]                   tcnt;
        logic [IW-1:0]                pi;
        logic [IW-1:0]                dlt;
        logic [N_ENC-1:0][2:0]        enc;
        logic [BLK_LEN-1:0]           mem;
    } st_t;

    st_t q, d;

    logic [N_ENC-1:0]      uin;
    logic [N_ENC-1:0]      par;
    logic [N_ENC-1:0]      tsys;
    logic [N_ENC-1:0][2:0] nxt;
    logic                  term;
    logic                  keep1, keep2, wrap;
    logic                  bit_c;

    for (genvar g = 0; g < N_ENC; g++) begin : g_rsc
        tc_rsc_core u_core (
            .state_i (q.enc[g]),
            .u_i     (uin[g]),
            .term_i  (term),
            .par_o   (par[g]),
            .tail_o  (tsys[g]),
            .next_o  (nxt[g])
        );
    end

    tc_punct u_punct (
        .rate_i  (q.rate),
        .phase_i (q.ph),
        .keep1_o (keep1),
        .keep2_o (keep2),
        .wrap_o  (wrap)
    );

    always_comb begin
        d      = q;
        bit_c  = 1'b0;
        term   = (q.st == S_TAIL);
        uin[0] = q.mem[q.idx];
        uin[1] = q.mem[q.pi];
        case (q.st)
            S_FILL: begin
                if (in_valid) begin
                    if (q.idx == '0) d.rate = rate_e'(in_rate);
                    d.mem[q.idx] = in_bit;
                    d.idx        = q.idx + 1'b1;
                    if (q.idx == LAST_IDX) begin
                        d.st  = S_CODE;
                        d.idx = '0;
                        d.sub = 2'd0;
                        d.ph  = 4'd0;
                        d.pi  = '0;
                        d.dlt = DLT0;
                    end
                end
            end
            S_CODE: begin
                logic adv;
                adv = 1'b0;
                case (q.sub)
                    2'd0: begin
                        bit_c = q.mem[q.idx];
                        if (keep1)      d.sub = 2'd1;
                        else if (keep2) d.sub = 2'd2;
                        else            adv   = 1'b1;
                    end
                    2'd1: begin
                        bit_c = par[0];
                        if (keep2) d.sub = 2'd2;
                        else       adv   = 1'b1;
                    end
                    default: begin
                        bit_c = par[1];
                        adv   = 1'b1;
                    end
                endcase
                if (adv) begin
                    d.enc = nxt;
                    d.sub = 2'd0;
                    d.ph  = wrap ? 4'd0 : q.ph + 4'd1;
                    d.idx = q.idx + 1'b1;
                    d.pi  = q.pi + q.dlt;
                    d.dlt = q.dlt + DLT_INC;
                    if (q.idx == LAST_IDX) begin
                        d.st   = S_TAIL;
                        d.tcnt = 4'd0;
                    end
                end
            end
            S_TAIL: begin
                case (q.tcnt[1:0])
                    2'd0:    bit_c = tsys[0];
                    2'd1:    bit_c = par[0];
                    2'd2:    bit_c = tsys[1];
                    default: bit_c = par[1];
                endcase
                if (q.tcnt[1:0] == 2'd3) d.enc = nxt;
                d.tcnt = q.tcnt + 4'd1;
                if (q.tcnt == TAIL_END) begin
                    d.st  = S_FILL;
                    d.idx = '0;
                end
            end
            default: d.st = S_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_FILL;
            q.rate <= RATE_1_3;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == S_FILL);
    assign out_valid = (q.st != S_FILL);
    assign out_bit   = bit_c;
    assign out_last  = (q.st == S_TAIL) && (q.tcnt == TAIL_END);

    // R4: encoders enter each block from the all-zero state
    p_fresh_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (q.enc == '0));

    // R8: tail drives both encoders back to zero
    p_term_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (q.enc == '0));

    // R9: buffer reopens right after the final tail bit
    p_ready_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (in_ready && !out_valid));

    // R9: no gap inside a coded block
    p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R3: sampled rate holds while the block is coded
    p_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(q.rate));
endmodule

// File: tb/tb_tc_turbo_enc.sv
module tb_tc_turbo_enc;
    localparam int CLK_PERIOD = 10;
    localparam int K          = 512;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_bit;
    logic [1:0] in_rate;
    logic out_valid, out_bit, out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit exp_bit[$];
    bit exp_last[$];
    bit data[K];

    always #(CLK_PERIOD/2) clk = ~clk;

    tc_turbo_enc dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_rate(in_rate),
        .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the whole code; pushes expected bits.
    task automatic model(input int rate);
        int h1[3];
        int h2[3];
        int pos, per, k1, k2;
        for (int j = 0; j < 3; j++) begin h1[j] = 0; h2[j] = 0; end
        case (rate)
            1: begin per = 2;  k1 = 0; k2 = 1; end
            2: begin per = 4;  k1 = 0; k2 = 2; end
            3: begin per = 14; k1 = 0; k2 = 7; end
            default: begin per = 1; k1 = 0; k2 = 0; end
        endcase
        for (int i = 0; i < K; i++) begin
            int u1, u2, a1, a2, p1, p2;
            longint li;
            li  = longint'(i);
            pos = int'((31 * li + 64 * li * li) % K);
            u1 = data[i];
            u2 = data[pos];
            a1 = u1 ^ h1[1] ^ h1[2];
            a2 = u2 ^ h2[1] ^ h2[2];
            p1 = a1 ^ h1[0] ^ h1[2];
            p2 = a2 ^ h2[0] ^ h2[2];
            exp_bit.push_back(bit'(u1)); exp_last.push_back(1'b0);
            if ((i % per) == k1) begin exp_bit.push_back(bit'(p1)); exp_last.push_back(1'b0); end
            if ((i % per) == k2) begin exp_bit.push_back(bit'(p2)); exp_last.push_back(1'b0); end
            h1[2] = h1[1]; h1[1] = h1[0]; h1[0] = a1;
            h2[2] = h2[1]; h2[1] = h2[0]; h2[0] = a2;
        end
        for (int t = 0; t < 3; t++) begin
            int x1, x2;
            x1 = h1[1] ^ h1[2];
            x2 = h2[1] ^ h2[2];
            exp_bit.push_back(bit'(x1));                 exp_last.push_back(1'b0);
            exp_bit.push_back(bit'(h1[0] ^ h1[2]));      exp_last.push_back(1'b0);
            exp_bit.push_back(bit'(x2));                 exp_last.push_back(1'b0);
            exp_bit.push_back(bit'(h2[0] ^ h2[2]));      exp_last.push_back(t == 2);
            h1[2] = h1[1]; h1[1] = h1[0]; h1[0] = 0;
            h2[2] = h2[1]; h2[1] = h2[0]; h2[0] = 0;
        end
    endtask

    // Output comparison every cycle, away from the active edge (R6, R7, R8, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_bit.size() == 0) begin
                    chk(1'b0, "R2 coded bit with none expected", 1, 0);
                end else begin
                    bit eb, el;
                    eb = exp_bit.pop_front();
                    el = exp_last.pop_front();
                    chk(out_bit == eb, "R6/R7/R8 coded bit", int'(out_bit), int'(eb));
                    chk(out_last == el, "R9 last marker", int'(out_last), int'(el));
                    chk(!in_ready, "R2 ready low while coding", int'(in_ready), 0);
                end
            end else if (exp_bit.size() != 0 && !in_ready) begin
                chk(1'b0, "R9 gap in coded stream", 0, 1);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            chk(1'b0, "watchdog expired", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // kind: 0 random, 1 all ones, 2 alternating
    task automatic run_block(input int rate, input int kind, input bit gaps, input bit flip_rate);
        for (int i = 0; i < K; i++) begin
            case (kind)
                1:       data[i] = 1'b1;
                2:       data[i] = bit'(i % 2);
                default: data[i] = bit'($urandom_range(1, 0));
            endcase
        end
        model(rate);
        for (int i = 0; i < K; i++) begin
            @(negedge clk);
            if (gaps && (i % 5 == 2)) begin
                in_valid = 1'b0;
                in_rate  = 2'(~rate);
                @(negedge clk);
                chk(!out_valid, "R10 no output during idle input", int'(out_valid), 0);
            end
            in_valid = 1'b1;
            in_bit   = data[i];
            in_rate  = (flip_rate && i > 0) ? 2'(~rate) : 2'(rate);
            chk(in_ready, "R2 ready while filling", int'(in_ready), 1);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (exp_bit.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(in_ready && !out_valid, "R9 ready after last bit", int'(in_ready), 1);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_bit   = 1'b0;
        in_rate  = 2'b00;
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

        run_block(0, 0, 1'b0, 1'b0);   // R4 R5 rate 1/3
        run_block(1, 0, 1'b1, 1'b0);   // R7 rate 1/2 with idle gaps (R10)
        run_block(2, 2, 1'b0, 1'b0);   // R7 rate 2/3 alternating data
        run_block(3, 0, 1'b0, 1'b0);   // R7 rate 7/8 partial final period
        run_block(1, 1, 1'b0, 1'b0);   // R8 all ones, heavy feedback
        run_block(3, 0, 1'b0, 1'b1);   // R3 rate change after first bit ignored
        run_block(0, 2, 1'b1, 1'b1);   // R3 R10 combined

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule